// File: doc/BRIEF.md
# Capture/Compare Timer Channel

A 16-bit up-counter paired with one capture/compare register. A mode input sets the role of the register. In compare mode the register is checked against the running count on every clock. Equality produces a single-cycle interrupt pulse. In capture mode, a qualified transition on an external trigger pin copies the running count into the register and also pulses the interrupt.

Software loads the register through a write strobe and reads it back continuously. While the counter is stopped, a write always lands. While the counter is running, a write lands only when the pulse-generation mode flag is set. The trigger pin is asynchronous. It is resynchronised by two flops before its edges are detected, and the edge of interest is chosen with a 2-bit code that has one dead value.

Top module: `tmr_capcmp`

## Requirements
- R1: While rst is high at a rising clock edge, count_out becomes 0, rd_data becomes 0 and irq becomes 0.
- R2: count_out increases by one per clock while run_en is 1, holds while run_en is 0, and wraps from 16'hFFFF to 16'h0000.
- R3: With capture_mode 0, irq is high for exactly one clock, in the clock after the one in which count_out equals rd_data.
- R4: When the count stops while equal to the register, irq pulses once and not again for as long as the equality lasts.
- R5: With the register at 16'h0000 in compare mode, no pulse follows reset release; the pulse comes one clock after the count wraps to 16'h0000, when count_out reads 16'h0001.
- R6: With capture_mode 1, a qualified pin change applied while count_out shows value C appears in rd_data as C+2 after the third rising edge. irq is high for that one clock only.
- R7: edge_sel selects the qualifying trigger change: 2'b00 falling only, 2'b01 rising only, 2'b11 both, 2'b10 none.
- R8: While run_en is 0, trigger changes never alter rd_data and never pulse irq.
- R9: A write with wr_en lands in rd_data on the next clock when run_en is 0 or ppg_mode is 1. When run_en is 1 and ppg_mode is 0, the write is ignored.
- R10: When a capture and an accepted write fall on the same edge, the captured count is stored and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Counter enable |
| capture_mode | input | 1 | 1 = register captures, 0 = register compares |
| edge_sel | input | 2 | Trigger edge code (00 fall, 01 rise, 10 none, 11 both) |
| trig_in | input | 1 | Asynchronous capture trigger pin |
| ppg_mode | input | 1 | Allows register writes while counting |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Current register contents |
| count_out | output | 16 | Current count |
| irq | output | 1 | One-cycle match or capture pulse |

## Verification
A capture and a software write can fall on the same clock edge. The bench provokes this with the counter running in pulse-generation mode. It toggles the trigger and then raises the write strobe in the clock where the synchronised edge is about to load the register. The check passes only if the register then holds the predicted count rather than the written value, and irq pulses.

// File: rtl/tmr_capcmp_pkg.sv
package tmr_capcmp_pkg;

    localparam int TMR_W      = 16;
    localparam int TMR_SYNC_N = 2;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_NONE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_code_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    // Decide whether the detected transition qualifies under the selected code.
    function automatic logic edge_qualifies(input edge_code_e code, input edge_ev_t ev);
        logic hit;
        case (code)
            EDGE_FALL: hit = ev.fall;
            EDGE_RISE: hit = ev.rise;
            EDGE_BOTH: hit = ev.rise | ev.fall;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/tmr_trig_sync.sv
module tmr_trig_sync
    import tmr_capcmp_pkg::*;
#(
    parameter int STAGES = TMR_SYNC_N
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin,
    output edge_ev_t ev
);
    localparam int LAST = STAGES;

    logic [LAST:0] pipe_q;

    genvar g;
    generate
        for (g = 0; g <= LAST; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe_q[g] <= 1'b0;
                    else     pipe_q[g] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe_q[g] <= 1'b0;
                    else     pipe_q[g] <= pipe_q[g-1];
                end
            end
        end
    endgenerate

    // pipe_q[LAST-1] is the settled level, pipe_q[LAST] its previous value
    always_comb begin
        ev.rise = pipe_q[LAST-1] & ~pipe_q[LAST];
        ev.fall = ~pipe_q[LAST-1] & pipe_q[LAST];
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_en,
    output logic [W-1:0] cnt_q
);
    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (run_en) cnt_q <= cnt_q + W'(1);
    end
endmodule

// File: rtl/tmr_ccr.sv
module tmr_ccr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_en,
    input  logic         capture_mode,
    input  logic         ppg_mode,
    input  logic         edge_hit,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] ccr_q,
    output logic         cap_evt
);
    logic wr_ok;

    always_comb begin
        cap_evt = capture_mode & run_en & edge_hit;
        wr_ok   = wr_en & (~run_en | ppg_mode);
    end

    // Capture takes priority so the stored count is never lost to a write.
    always_ff @(posedge clk) begin
        if (rst)          ccr_q <= '0;
        else if (cap_evt) ccr_q <= cnt;
        else if (wr_ok)   ccr_q <= wr_data;
    end
endmodule

// File: rtl/tmr_irq_gen.sv
module tmr_irq_gen #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture_mode,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] ccr,
    input  logic         cap_evt,
    output logic         irq_q
);
    logic match_now;
    logic match_d;

    assign match_now = ~capture_mode & (cnt == ccr);

    // match_d resets high so the zero/zero state after reset is not an event.
    always_ff @(posedge clk) begin
        if (rst) begin
            match_d <= 1'b1;
            irq_q   <= 1'b0;
        end else begin
            match_d <= match_now;
            irq_q   <= (match_now & ~match_d) | cap_evt;
        end
    end
endmodule

// File: rtl/tmr_capcmp.sv
module tmr_capcmp
    import tmr_capcmp_pkg::*;
#(
    parameter int CNT_W  = TMR_W,
    parameter int SYNC_N = TMR_SYNC_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             capture_mode,
    input  logic [1:0]       edge_sel,
    input  logic             trig_in,
    input  logic             ppg_mode,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    output logic [CNT_W-1:0] count_out,
    output logic             irq
);
    edge_ev_t         trig_ev;
    logic             edge_hit;
    logic             cap_evt;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ccr_q;

    tmr_trig_sync #(.STAGES(SYNC_N)) sync_i (
        .clk (clk),
        .rst (rst),
        .pin (trig_in),
        .ev  (trig_ev)
    );

    assign edge_hit = edge_qualifies(edge_code_e'(edge_sel), trig_ev);

    tmr_counter #(.W(CNT_W)) cnt_i (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .cnt_q  (cnt_q)
    );

    tmr_ccr #(.W(CNT_W)) ccr_i (
        .clk          (clk),
        .rst          (rst),
        .run_en       (run_en),
        .capture_mode (capture_mode),
        .ppg_mode     (ppg_mode),
        .edge_hit     (edge_hit),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .cnt          (cnt_q),
        .ccr_q        (ccr_q),
        .cap_evt      (cap_evt)
    );

    tmr_irq_gen #(.W(CNT_W)) irq_i (
        .clk          (clk),
        .rst          (rst),
        .capture_mode (capture_mode),
        .cnt          (cnt_q),
        .ccr          (ccr_q),
        .cap_evt      (cap_evt),
        .irq_q        (irq)
    );

    assign rd_data   = ccr_q;
    assign count_out = cnt_q;
endmodule

// File: rtl/tmr_capcmp_chk.sv
module tmr_capcmp_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         run_en,
    input logic         capture_mode,
    input logic         ppg_mode,
    input logic         wr_en,
    input logic [W-1:0] rd_data,
    input logic [W-1:0] count_out,
    input logic         irq
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (count_out == '0 && rd_data == '0 && !irq));

    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        run_en |=> count_out == $past(count_out) + W'(1));

    a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> $stable(count_out));

    a_r3_match_cause: assert property (@(posedge clk) disable iff (rst)
        (irq && !$past(capture_mode)) |-> $past(count_out) == $past(rd_data));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (irq && !capture_mode) |=> !irq);

    a_r8_stopped_no_capture: assert property (@(posedge clk) disable iff (rst)
        (!run_en && capture_mode && !wr_en) |=> ($stable(rd_data) && !irq));

    a_r9_write_blocked: assert property (@(posedge clk) disable iff (rst)
        (run_en && !ppg_mode && !capture_mode) |=> $stable(rd_data));
endmodule

bind tmr_capcmp tmr_capcmp_chk #(.W(CNT_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .run_en       (run_en),
    .capture_mode (capture_mode),
    .ppg_mode     (ppg_mode),
    .wr_en        (wr_en),
    .rd_data      (rd_data),
    .count_out    (count_out),
    .irq          (irq)
);

// File: tb/tmr_capcmp_tb_top.sv
module tmr_capcmp_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    // {edge_sel[1:0], start level, end level, capture expected}
    localparam logic [4:0] VEC_TBL [0:7] = '{
        5'b00_1_0_1, 5'b00_0_1_0,
        5'b01_0_1_1, 5'b01_1_0_0,
        5'b11_0_1_1, 5'b11_1_0_1,
        5'b10_0_1_0, 5'b10_1_0_0
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         run_en = 1'b0;
    logic         capture_mode = 1'b0;
    logic [1:0]   edge_sel = 2'b00;
    logic         trig_in = 1'b0;
    logic         ppg_mode = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic [W-1:0] count_out;
    logic         irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_capcmp dut_i (
        .clk          (clk),
        .rst          (rst),
        .run_en       (run_en),
        .capture_mode (capture_mode),
        .edge_sel     (edge_sel),
        .trig_in      (trig_in),
        .ppg_mode     (ppg_mode),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .count_out    (count_out),
        .irq          (irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] c0;
        logic [W-1:0] old;
        int pulses;
        int bad;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(count_out == 0, "R1 count", int'(count_out), 0);
        check(rd_data == 0, "R1 register", int'(rd_data), 0);
        check(irq == 1'b0, "R1 irq", int'(irq), 0);
        @(negedge clk);
        check(irq == 1'b0, "R5 no pulse after reset while stopped", int'(irq), 0);

        // R9 write while stopped, then R3 compare pulse
        wr_en = 1'b1; wr_data = 16'd5;
        @(negedge clk);
        wr_en = 1'b0;
        check(rd_data == 16'd5, "R9 write while stopped", int'(rd_data), 5);
        run_en = 1'b1;
        pulses = 0; bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (irq) begin
                pulses++;
                if (count_out != 16'd6) bad++;
            end
        end
        check(pulses == 1, "R3 pulse count", pulses, 1);
        check(bad == 0, "R3 pulse timing", bad, 0);
        check(count_out == 16'd20, "R2 count advance", int'(count_out), 20);
        run_en = 1'b0;
        @(negedge clk);
        check(count_out == 16'd20, "R2 count hold", int'(count_out), 20);

        // R4 stop on equality
        wr_en = 1'b1; wr_data = 16'd25;
        @(negedge clk);
        wr_en = 1'b0;
        run_en = 1'b1;
        while (count_out != 16'd25) @(negedge clk);
        run_en = 1'b0;
        pulses = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (irq) pulses++;
        end
        check(pulses == 1, "R4 single pulse while equal", pulses, 1);

        // R9 writes while running
        run_en = 1'b1; ppg_mode = 1'b0;
        wr_en = 1'b1; wr_data = 16'h1234;
        @(negedge clk);
        wr_en = 1'b0;
        check(rd_data == 16'd25, "R9 write ignored while running", int'(rd_data), 25);
        ppg_mode = 1'b1;
        wr_en = 1'b1; wr_data = 16'h4321;
        @(negedge clk);
        wr_en = 1'b0; ppg_mode = 1'b0;
        check(rd_data == 16'h4321, "R9 write accepted in ppg mode", int'(rd_data), 16'h4321);
        run_en = 1'b0;

        // R6/R7 capture vector table
        capture_mode = 1'b1;
        for (int i = 0; i < 8; i++) begin
            logic [4:0] v;
            v = VEC_TBL[i];
            run_en = 1'b0;
            edge_sel = v[4:3];
            trig_in = v[2];
            repeat (4) @(negedge clk);
            old = rd_data;
            run_en = 1'b1;
            repeat (2) @(negedge clk);
            trig_in = v[1];
            c0 = count_out;
            repeat (3) @(negedge clk);
            if (v[0]) begin
                check(rd_data == W'(c0 + 2), "R6 R7 captured value", int'(rd_data), int'(W'(c0 + 2)));
                check(irq == 1'b1, "R6 capture pulse", int'(irq), 1);
            end else begin
                check(rd_data == old, "R7 no capture for code", int'(rd_data), int'(old));
                check(irq == 1'b0, "R7 no pulse for code", int'(irq), 0);
            end
            @(negedge clk);
            check(irq == 1'b0, "R6 pulse width", int'(irq), 0);
        end

        // R8 trigger while stopped
        run_en = 1'b0; edge_sel = 2'b11;
        repeat (4) @(negedge clk);
        old = rd_data;
        trig_in = ~trig_in;
        pulses = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (irq) pulses++;
        end
        check(rd_data == old, "R8 stopped capture ignored", int'(rd_data), int'(old));
        check(pulses == 0, "R8 stopped no pulse", pulses, 0);

        // R10 capture collides with accepted write
        ppg_mode = 1'b1; run_en = 1'b1;
        repeat (2) @(negedge clk);
        trig_in = ~trig_in;
        c0 = count_out;
        repeat (2) @(negedge clk);
        wr_en = 1'b1; wr_data = 16'hBEEF;
        @(negedge clk);
        wr_en = 1'b0;
        check(rd_data == W'(c0 + 2), "R10 capture wins over write", int'(rd_data), int'(W'(c0 + 2)));
        check(irq == 1'b1, "R10 capture pulse", int'(irq), 1);
        ppg_mode = 1'b0;

        // R5 rollover with zero compare value
        capture_mode = 1'b0; run_en = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        run_en = 1'b1;
        pulses = 0;
        while (count_out != 16'hFFFE) begin
            @(negedge clk);
            if (irq) pulses++;
        end
        check(pulses == 0, "R5 no pulse before wrap", pulses, 0);
        @(negedge clk);
        check(count_out == 16'hFFFF && irq == 1'b0, "R5 at FFFF", int'(irq), 0);
        @(negedge clk);
        check(count_out == 16'h0000, "R2 wrap to zero", int'(count_out), 0);
        check(irq == 1'b0, "R5 no pulse at zero", int'(irq), 0);
        @(negedge clk);
        check(count_out == 16'h0001 && irq == 1'b1, "R5 pulse after wrap", int'(irq), 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule